// File: doc/BRIEF.md
# UART Automatic Hardware Flow Control

This block makes the modem-control handshake of a UART automatic. On the transmit side it watches the clear-to-send input and decides whether the transmitter may begin its next character. It makes that decision only while the transmitter sits between characters, so a character already on the line always completes. On the receive side it compares the receive FIFO fill count with a four-step trigger ladder of 1, 4, 8 and 14 bytes. From that comparison it raises a receive-trigger interrupt and drives the request-to-send pin.

The request-to-send output has hysteresis across the ladder. The interrupt fires at the programmed trigger level. The pin goes to 1 only at the next level up, which is a full FIFO when the programmed level is the top one. The pin returns to 0 only once the fill is below the level under the programmed one, which is an empty FIFO when the programmed level is the bottom one. When automatic RTS is off, the pin copies a software bit. Both automatic modes come out of reset disabled. The signals here are control and status levels, not data streams, so none of them has a valid/ready handshake. The clear-to-send input passes through a synchronizer, and every output comes from a register.

Top module: `afc_flow_ctrl`

## Requirements
- R1: After reset, tx_permit is 1, rts_pin is 0, rx_trig_irq is 0 and flow_stat is 2'b00.
- R2: With auto_cts_en=1 and tx_busy=0, cts_pin=1 drives tx_permit to 0 on the third rising edge after the pin changes (two synchronizer stages and one gate register).
- R3: With auto_cts_en=1 and tx_busy=0, cts_pin returning to 0 drives tx_permit back to 1 on the third rising edge.
- R4: While tx_busy=1, tx_permit holds its value. The pending CTS state is applied on the first edge at which tx_busy=0.
- R5: With auto_cts_en=0, tx_permit is 1 whatever the level of cts_pin.
- R6: rx_trig_irq is 1 one edge after rx_fill is at or above the programmed level, and 0 one edge after rx_fill is below it. trig_sel 0,1,2,3 selects 1,4,8,14 bytes.
- R7: With auto_rts_en=1, rts_pin goes to 1 one edge after rx_fill reaches the assert point. The assert points are 4, 8, 14 and 16 for trig_sel 0,1,2,3.
- R8: With auto_rts_en=1, once rts_pin is 1 it stays 1 until rx_fill drops below the release point. The release points are 1, 1, 4 and 8 for trig_sel 0,1,2,3, so a fill of 0, 0, 3 or 7 lowers it. It goes to 0 one edge later.
- R9: With auto_rts_en=0, rts_pin equals sw_rts one edge later.
- R10: flow_stat[0] is 1 exactly while the hardware holds rts_pin at 1. flow_stat[1] is 1 exactly while the CTS gate holds tx_permit at 0. Both update on the same edge as the output they describe.
- R11: Clearing auto_rts_en drops the hardware hold at the next edge. If the mode is enabled again, it starts from the released state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| auto_cts_en | input | 1 | Enables automatic CTS gating of the transmitter |
| auto_rts_en | input | 1 | Enables automatic RTS from the FIFO fill |
| trig_sel | input | 2 | Receive trigger select: 0=1, 1=4, 2=8, 3=14 bytes |
| rx_fill | input | $clog2(DEPTH+1) | Current receive FIFO fill count |
| cts_pin | input | 1 | Clear-to-send pin, asynchronous; 1 means stop |
| sw_rts | input | 1 | Software RTS bit, used when automatic RTS is off |
| tx_busy | input | 1 | Transmitter is shifting a character |
| tx_permit | output | 1 | Transmitter may start the next character |
| rts_pin | output | 1 | Request-to-send pin level; 1 means stop |
| rx_trig_irq | output | 1 | Receive-trigger interrupt request |
| flow_stat | output | 2 | Bit 0: RTS held by hardware; bit 1: transmitter held by CTS |

## Verification
The fill count is walked up and down across every trigger select. Values just below and at each interrupt level separate the interrupt threshold from the RTS assert point. Values just above and at each release point show that the pin remembers its history instead of following the fill level. The CTS pin is toggled while the transmitter is idle and while it is busy, which separates the synchronizer latency from the hold at character boundaries. CTS is also toggled with the mode disabled, which shows that the pin has no effect in that state. Toggling the software RTS bit and switching the automatic RTS mode off in the middle of a hold shows which source the pin follows and that the hold is cleared.

// File: rtl/afc_pkg.sv
package afc_pkg;

  typedef struct packed {
    logic cts_hold;
    logic rts_hold;
  } afc_stat_t;

  function automatic int ladder_pick(input logic [1:0] sel,
                                     input int l0, input int l1,
                                     input int l2, input int l3);
    case (sel)
      2'd0:    return l0;
      2'd1:    return l1;
      2'd2:    return l2;
      default: return l3;
    endcase
  endfunction

endpackage

// File: rtl/afc_sync.sv
module afc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/afc_tx_gate.sv
module afc_tx_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic auto_cts_en,
  input  logic cts_s,
  input  logic tx_busy,
  output logic tx_permit,
  output logic cts_hold
);
  logic hold_q;

  // The stop decision is only revisited between characters.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hold_q <= 1'b0;
    else if (!tx_busy) hold_q <= auto_cts_en & cts_s;
  end

  assign tx_permit = ~hold_q;
  assign cts_hold  = hold_q;
endmodule

// File: rtl/afc_rts_ctrl.sv
module afc_rts_ctrl
  import afc_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LVL0  = 1,
  parameter int LVL1  = 4,
  parameter int LVL2  = 8,
  parameter int LVL3  = 14,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             auto_rts_en,
  input  logic [1:0]       trig_sel,
  input  logic [CNT_W-1:0] rx_fill,
  input  logic             sw_rts,
  output logic             rts_pin,
  output logic             rx_trig_irq,
  output logic             rts_hold
);
  localparam int NLVL = 4;

  logic [NLVL-1:0][CNT_W-1:0] trig_pt;
  logic [NLVL-1:0][CNT_W-1:0] asrt_pt;
  logic [NLVL-1:0][CNT_W-1:0] rel_pt;

  // Assert point is one step up the ladder; release point one step down.
  genvar g;
  generate
    for (g = 0; g < NLVL; g++) begin : g_ladder
      localparam int TRIG = ladder_pick(2'(g), LVL0, LVL1, LVL2, LVL3);
      localparam int ASRT = (g == NLVL-1) ? DEPTH
                          : ladder_pick(2'(g+1), LVL0, LVL1, LVL2, LVL3);
      localparam int REL  = (g == 0) ? 1
                          : ladder_pick(2'(g-1), LVL0, LVL1, LVL2, LVL3);
      assign trig_pt[g] = CNT_W'(TRIG);
      assign asrt_pt[g] = CNT_W'(ASRT);
      assign rel_pt[g]  = CNT_W'(REL);
    end
  endgenerate

  logic hold_q, hold_d, rts_q, irq_q;

  always_comb begin
    if (!auto_rts_en)  hold_d = 1'b0;
    else if (hold_q)   hold_d = (rx_fill >= rel_pt[trig_sel]);
    else               hold_d = (rx_fill >= asrt_pt[trig_sel]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      rts_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      hold_q <= hold_d;
      rts_q  <= auto_rts_en ? hold_d : sw_rts;
      irq_q  <= (rx_fill >= trig_pt[trig_sel]);
    end
  end

  assign rts_pin     = rts_q;
  assign rx_trig_irq = irq_q;
  assign rts_hold    = hold_q;
endmodule

// File: rtl/afc_flow_ctrl.sv
module afc_flow_ctrl
  import afc_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int LVL0        = 1,
  parameter int LVL1        = 4,
  parameter int LVL2        = 8,
  parameter int LVL3        = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       auto_cts_en,
  input  logic                       auto_rts_en,
  input  logic [1:0]                 trig_sel,
  input  logic [$clog2(DEPTH+1)-1:0] rx_fill,
  input  logic                       cts_pin,
  input  logic                       sw_rts,
  input  logic                       tx_busy,
  output logic                       tx_permit,
  output logic                       rts_pin,
  output logic                       rx_trig_irq,
  output logic [1:0]                 flow_stat
);
  logic      cts_s;
  afc_stat_t stat;

  afc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(cts_pin), .q_sync(cts_s)
  );

  afc_tx_gate u_tx_gate (
    .clk(clk), .rst_n(rst_n), .auto_cts_en(auto_cts_en), .cts_s(cts_s),
    .tx_busy(tx_busy), .tx_permit(tx_permit), .cts_hold(stat.cts_hold)
  );

  afc_rts_ctrl #(
    .DEPTH(DEPTH), .LVL0(LVL0), .LVL1(LVL1), .LVL2(LVL2), .LVL3(LVL3)
  ) u_rts_ctrl (
    .clk(clk), .rst_n(rst_n), .auto_rts_en(auto_rts_en), .trig_sel(trig_sel),
    .rx_fill(rx_fill), .sw_rts(sw_rts), .rts_pin(rts_pin),
    .rx_trig_irq(rx_trig_irq), .rts_hold(stat.rts_hold)
  );

  assign flow_stat = stat;
endmodule

// File: rtl/afc_flow_chk.sv
module afc_flow_chk #(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             auto_cts_en,
  input logic             auto_rts_en,
  input logic [CNT_W-1:0] rx_fill,
  input logic             sw_rts,
  input logic             tx_busy,
  input logic             tx_permit,
  input logic             rts_pin,
  input logic             rx_trig_irq,
  input logic [1:0]       flow_stat
);
  // R4: a busy transmitter never sees its permit change
  a_r4_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(tx_busy)) |-> $stable(tx_permit));

  // R5: without auto CTS an idle transmitter is always permitted
  a_r5_cts_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(auto_cts_en) && !$past(tx_busy)) |-> tx_permit);

  // R6: interrupt never set with an empty FIFO
  a_r6_irq_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rx_fill) == '0) |-> !rx_trig_irq);

  // R7: a full FIFO always raises RTS in auto mode
  a_r7_full_raises: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(auto_rts_en) && $past(rx_fill) == CNT_W'(DEPTH))
      |-> rts_pin);

  // R8: an empty FIFO always releases RTS in auto mode
  a_r8_empty_releases: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(auto_rts_en) && $past(rx_fill) == '0) |-> !rts_pin);

  // R9: manual mode copies the software bit
  a_r9_manual_follow: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(auto_rts_en)) |-> (rts_pin == $past(sw_rts)));

  // R10: status bits agree with the pins they report
  a_r10_rts_stat: assert property (@(posedge clk) disable iff (!rst_n)
    flow_stat[0] |-> rts_pin);
  a_r10_cts_stat: assert property (@(posedge clk) disable iff (!rst_n)
    flow_stat[1] |-> !tx_permit);
endmodule

bind afc_flow_ctrl afc_flow_chk #(.DEPTH(DEPTH)) u_flow_chk (
  .clk(clk), .rst_n(rst_n), .auto_cts_en(auto_cts_en),
  .auto_rts_en(auto_rts_en), .rx_fill(rx_fill), .sw_rts(sw_rts),
  .tx_busy(tx_busy), .tx_permit(tx_permit), .rts_pin(rts_pin),
  .rx_trig_irq(rx_trig_irq), .flow_stat(flow_stat)
);

// File: tb/afc_flow_ctrl_tb.sv
module afc_flow_ctrl_tb_top;
  localparam int DEPTH = 16;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic auto_cts_en = 1'b0, auto_rts_en = 1'b0;
  logic [1:0] trig_sel = 2'd0;
  logic [CNT_W-1:0] rx_fill = '0;
  logic cts_pin = 1'b0, sw_rts = 1'b0, tx_busy = 1'b0;
  logic tx_permit, rts_pin, rx_trig_irq;
  logic [1:0] flow_stat;

  always #4 clk = ~clk;  // 125 MHz

  afc_flow_ctrl #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .auto_cts_en(auto_cts_en),
    .auto_rts_en(auto_rts_en), .trig_sel(trig_sel), .rx_fill(rx_fill),
    .cts_pin(cts_pin), .sw_rts(sw_rts), .tx_busy(tx_busy),
    .tx_permit(tx_permit), .rts_pin(rts_pin), .rx_trig_irq(rx_trig_irq),
    .flow_stat(flow_stat)
  );

  typedef struct {
    string      tag;
    logic       permit;
    logic       rts;
    logic       irq;
    logic [1:0] stat;
  } exp_t;

  exp_t exp_q[$];
  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  // Driver: wait the design latency in falling edges, then queue the expectation.
  task automatic expect_after(input int lat, input string tag, input logic p,
                              input logic r, input logic i, input logic [1:0] s);
    exp_t e;
    repeat (lat) @(negedge clk);
    e.tag = tag; e.permit = p; e.rts = r; e.irq = i; e.stat = s;
    exp_q.push_back(e);
    #1;
  endtask

  task automatic set_fill(input int f, input string tag, input logic r,
                          input logic i, input logic [1:0] s);
    rx_fill = CNT_W'(f);
    expect_after(1, tag, 1'b1, r, i, s);
  endtask

  // Monitor: pops expectations and compares against the outputs.
  initial begin
    exp_t e;
    forever begin
      wait (exp_q.size() > 0);
      e = exp_q.pop_front();
      n_checks++;
      if ({tx_permit, rts_pin, rx_trig_irq, flow_stat} !==
          {e.permit, e.rts, e.irq, e.stat}) begin
        n_fail++;
        $display("FAIL %s: got permit=%b rts=%b irq=%b stat=%b, expected permit=%b rts=%b irq=%b stat=%b",
                 e.tag, tx_permit, rts_pin, rx_trig_irq, flow_stat,
                 e.permit, e.rts, e.irq, e.stat);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got hung, expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    expect_after(1, "R1 reset state", 1, 0, 0, 2'b00);

    // R9 manual RTS
    sw_rts = 1'b1; expect_after(1, "R9 sw_rts=1", 1, 1, 0, 2'b00);
    sw_rts = 1'b0; expect_after(1, "R9 sw_rts=0", 1, 0, 0, 2'b00);

    // R5 CTS ignored when disabled
    cts_pin = 1'b1; expect_after(3, "R5 cts ignored", 1, 0, 0, 2'b00);

    // R2 / R3
    auto_cts_en = 1'b1; expect_after(1, "R2 stop on cts", 0, 0, 0, 2'b10);
    cts_pin = 1'b0; expect_after(2, "R3 not yet resumed", 0, 0, 0, 2'b10);
    expect_after(1, "R3 resume", 1, 0, 0, 2'b00);
    cts_pin = 1'b1; expect_after(3, "R2 stop after sync", 0, 0, 0, 2'b10);
    cts_pin = 1'b0; expect_after(3, "R3 resume again", 1, 0, 0, 2'b00);

    // R4 hold while busy
    tx_busy = 1'b1; cts_pin = 1'b1;
    expect_after(5, "R4 busy holds permit", 1, 0, 0, 2'b00);
    tx_busy = 1'b0; expect_after(1, "R4 applied at boundary", 0, 0, 0, 2'b10);
    cts_pin = 1'b0; expect_after(3, "R3 resume idle", 1, 0, 0, 2'b00);
    auto_cts_en = 1'b0;

    // R6 interrupt thresholds
    trig_sel = 2'd1;
    set_fill(3,  "R6 sel1 below", 0, 0, 2'b00);
    set_fill(4,  "R6 sel1 at",    0, 1, 2'b00);
    set_fill(3,  "R6 sel1 clear", 0, 0, 2'b00);
    trig_sel = 2'd3;
    set_fill(13, "R6 sel3 below", 0, 0, 2'b00);
    set_fill(14, "R6 sel3 at",    0, 1, 2'b00);
    trig_sel = 2'd2;
    set_fill(8,  "R6 sel2 at",    0, 1, 2'b00);
    set_fill(7,  "R6 sel2 below", 0, 0, 2'b00);

    // R7 / R8 hysteresis
    auto_rts_en = 1'b1; trig_sel = 2'd1;
    set_fill(4,  "R7 sel1 irq not rts",  0, 1, 2'b00);
    set_fill(7,  "R7 sel1 below assert", 0, 1, 2'b00);
    set_fill(8,  "R7 sel1 assert",       1, 1, 2'b01);
    set_fill(3,  "R8 sel1 still held",   1, 0, 2'b01);
    set_fill(1,  "R8 sel1 held at 1",    1, 0, 2'b01);
    set_fill(0,  "R8 sel1 release",      0, 0, 2'b00);
    trig_sel = 2'd2;
    set_fill(13, "R7 sel2 below assert", 0, 1, 2'b00);
    set_fill(14, "R7 sel2 assert",       1, 1, 2'b01);
    set_fill(4,  "R8 sel2 held",         1, 0, 2'b01);
    set_fill(3,  "R8 sel2 release",      0, 0, 2'b00);
    trig_sel = 2'd3;
    set_fill(15, "R7 sel3 below full",   0, 1, 2'b00);
    set_fill(16, "R7 sel3 full",         1, 1, 2'b01);
    set_fill(8,  "R8 sel3 held",         1, 0, 2'b01);
    set_fill(7,  "R8 sel3 release",      0, 0, 2'b00);
    trig_sel = 2'd0;
    set_fill(3,  "R7 sel0 below",        0, 1, 2'b00);
    set_fill(4,  "R7 sel0 assert",       1, 1, 2'b01);
    set_fill(1,  "R8 sel0 held",         1, 1, 2'b01);
    set_fill(0,  "R8 sel0 release",      0, 0, 2'b00);

    // R11 disabling drops the hold
    set_fill(5, "R7 sel0 re-assert", 1, 1, 2'b01);
    auto_rts_en = 1'b0; rx_fill = CNT_W'(2);
    expect_after(1, "R11 disable drops hold", 1, 0, 1, 2'b00);
    auto_rts_en = 1'b1;
    expect_after(1, "R11 re-enable released", 1, 0, 1, 2'b00);
    sw_rts = 1'b1;
    expect_after(1, "R9 sw ignored in auto", 1, 0, 1, 2'b00);

    repeat (2) @(negedge clk);
    wait (exp_q.size() == 0);
    #1;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule